// File: doc/BRIEF.md
# Dual-Mode Processor Timer Bank

This block holds one timer per processor plus a shared mode register that is reached through the system timer's register window. Each processor timer runs in one of two modes. In counter mode it is a limit-match counter that raises an interrupt. In user mode it is a non-interrupting 63-bit counter that software starts and stops, and that software reads or loads as two 32-bit words.

The mode register has one bit per processor. A change of a bit triggers a defined transition sequence on the matching timer. The count advances on a one-cycle `tick` strobe, at a weight of bit 9 of the count value. Register access is a single-cycle port: a window select picks the timer, and a word offset picks the register. Read data is combinational. A reached-clearing read takes effect at the clock edge that ends the access.

Window 0 is the system timer window. Windows 1 to N_PROC are the processor timers. In the system timer window only the status and mode offsets are decoded here, because its counting path is handled elsewhere. A tick is dropped for a timer when, in the same cycle, that timer is written, undergoes a mode change, or is read at offset 0 in counter mode.

Top module: `cpu_timer_bank`

## Requirements
- R1: After reset the mode register reads 0. Every timer is in counter mode with status 1 (running), count 0, limit 0 and reached 0. No interrupt is raised.
- R2: The mode register is at offset 4 of window 0. Bit i selects user mode for the timer in window i+1. Written bits at or above N_PROC are dropped and read back 0. A write to offset 4 of a processor window changes nothing.
- R3: When a mode bit changes from 0 to 1, that timer's interrupt drops and its running flag clears. Its count value is kept.
- R4: When a mode bit changes from 1 to 0, that timer's count, limit and reached flag clear and its running flag is set. It then counts freely.
- R5: In user mode, offset 0 reads {reached, count[62:32]} and offset 1 reads {count[31:9], 9'b0}.
- R6: In user mode, a write to offset 0 loads count[62:32] from wdata[30:0]. A write to offset 1 loads count[31:9] from wdata[31:9]. Either write clears reached.
- R7: Offset 3 reads {31'b0, running} in a processor window and reads 0 in window 0. In user mode, a write to offset 3 sets running to wdata[0]. In counter mode such a write is ignored.
- R8: A user-mode timer that is running adds 1 at bit 9 of its 63-bit count per tick, with the carry passing from the low word into the high word. A stopped user-mode timer holds its count.
- R9: A timer in user mode never asserts its interrupt.
- R10: In counter mode, a write to offset 0 sets the limit to wdata[30:9] and clears the count and the interrupt. On a tick where count+1 equals a nonzero limit, the count returns to 0 and both reached and the interrupt are set. Otherwise the 22-bit count field advances and wraps.
- R11: In counter mode, offset 0 reads {1'b0, limit, 9'b0} and clears reached and the interrupt. Offset 1 reads {reached, count[30:9], 9'b0}. Writes to offset 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one count unit per pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for read side effects) |
| bus_sel | input | SEL_W | Window: 0 system timer, i for processor timer i |
| bus_off | input | 3 | Word offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| proc_irq | output | N_PROC | Interrupt per processor timer |

## Verification
The bench builds the bank with N_PROC = 4, which gives a 3-bit window select. Mode writes can then carry bits 4 and 5, which the block must drop. Random mode patterns leave user-mode and counter-mode timers side by side, so each mode's read and write map is exercised next to the other's. Small random limits make limit matches and their interrupts frequent. Loading the low word to its top value exercises the 63-bit carry without a long run.

// File: rtl/cpu_tmr_pkg.sv
package cpu_tmr_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned TICK_LSB = 9;
   localparam int unsigned CNT_W    = 63;
   localparam int unsigned TICK_W   = CNT_W - TICK_LSB;      // user count field
   localparam int unsigned LO_TW    = WORD_W - TICK_LSB;     // low-word count bits
   localparam int unsigned HI_W     = TICK_W - LO_TW;        // high-word count bits
   localparam int unsigned CTR_TW   = WORD_W - 1 - TICK_LSB; // counter-mode count bits

   typedef enum logic [2:0] {
      OFF_HI   = 3'd0,
      OFF_LO   = 3'd1,
      OFF_STAT = 3'd3,
      OFF_MODE = 3'd4
   } reg_off_e;
endpackage

// File: rtl/cpu_tmr_mode_reg.sv
module cpu_tmr_mode_reg #(
   parameter int unsigned N_PROC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mode,
   input  logic [N_PROC-1:0] wdata,
   output logic [N_PROC-1:0] mode,
   output logic [N_PROC-1:0] go_user,
   output logic [N_PROC-1:0] go_ctr
);
   logic [N_PROC-1:0] mode_q;

   assign go_user = {N_PROC{wr_mode}} & wdata & ~mode_q;
   assign go_ctr  = {N_PROC{wr_mode}} & ~wdata & mode_q;
   assign mode    = mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= wdata;
   end

   a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> $stable(mode_q));
   a_r3_user_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      (go_user != '0) |=> ((mode_q & $past(go_user)) == $past(go_user)));
   a_r4_user_bit_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (go_ctr != '0) |=> ((mode_q & $past(go_ctr)) == '0));
endmodule

// File: rtl/cpu_tmr_unit.sv
module cpu_tmr_unit
   import cpu_tmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr,
   input  logic              rd,
   input  logic [2:0]        off,
   input  logic [WORD_W-1:0] wdata,
   input  logic              user,
   input  logic              go_user,
   input  logic              go_ctr,
   output logic [WORD_W-1:0] rdata,
   output logic              irq
);
   logic [TICK_W-1:0] cnt_q;
   logic [CTR_TW-1:0] lim_q;
   logic              reached_q, run_q, irq_q;

   logic [CTR_TW-1:0] ctr_inc;
   logic              hit_lim;
   logic              unused_wdata;

   assign ctr_inc      = cnt_q[CTR_TW-1:0] + 1'b1;
   assign hit_lim      = (lim_q != '0) && (ctr_inc == lim_q);
   assign unused_wdata = ^wdata[TICK_LSB-1:1];
   assign irq          = irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         lim_q     <= '0;
         reached_q <= 1'b0;
         run_q     <= 1'b1;
         irq_q     <= 1'b0;
      end else if (go_user) begin
         irq_q <= 1'b0;
         run_q <= 1'b0;
      end else if (go_ctr) begin
         cnt_q     <= '0;
         lim_q     <= '0;
         reached_q <= 1'b0;
         run_q     <= 1'b1;
      end else if (wr) begin
         if (user) begin
            case (off)
               OFF_HI: begin
                  cnt_q[TICK_W-1:LO_TW] <= wdata[HI_W-1:0];
                  reached_q             <= 1'b0;
               end
               OFF_LO: begin
                  cnt_q[LO_TW-1:0] <= wdata[WORD_W-1:TICK_LSB];
                  reached_q        <= 1'b0;
               end
               OFF_STAT: run_q <= wdata[0];
               default: ;
            endcase
         end else if (off == OFF_HI) begin
            lim_q <= wdata[WORD_W-2:TICK_LSB];
            cnt_q <= '0;
            irq_q <= 1'b0;
         end
      end else if (rd && !user && off == OFF_HI) begin
         reached_q <= 1'b0;
         irq_q     <= 1'b0;
      end else if (tick && run_q) begin
         if (user) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (hit_lim) begin
            cnt_q     <= '0;
            reached_q <= 1'b1;
            irq_q     <= 1'b1;
         end else begin
            cnt_q <= TICK_W'(ctr_inc);
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (off)
         OFF_HI:   rdata = user ? {reached_q, cnt_q[TICK_W-1:LO_TW]}
                                : {1'b0, lim_q, {TICK_LSB{1'b0}}};
         OFF_LO:   rdata = user ? {cnt_q[LO_TW-1:0], {TICK_LSB{1'b0}}}
                                : {reached_q, cnt_q[CTR_TW-1:0], {TICK_LSB{1'b0}}};
         OFF_STAT: rdata = {{(WORD_W-1){1'b0}}, run_q};
         default:  rdata = '0;
      endcase
   end

   a_r9_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      user |-> !irq_q);
   a_r3_stop_on_user: assert property (@(posedge clk) disable iff (!rst_n)
      go_user |=> (!run_q && !irq_q));
   a_r4_restart_ctr: assert property (@(posedge clk) disable iff (!rst_n)
      go_ctr |=> (run_q && cnt_q == '0 && !reached_q));
   a_r8_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (user && !run_q && !wr && !go_ctr) |=> $stable(cnt_q));
   a_r10_ctr_running: assert property (@(posedge clk) disable iff (!rst_n)
      !user |-> run_q);
endmodule

// File: rtl/cpu_timer_bank.sv
module cpu_timer_bank
   import cpu_tmr_pkg::*;
#(
   parameter int unsigned N_PROC = 4,
   parameter int unsigned SEL_W  = $clog2(N_PROC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [SEL_W-1:0]  bus_sel,
   input  logic [2:0]        bus_off,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic [N_PROC-1:0] proc_irq
);
   if (N_PROC < 1 || N_PROC > WORD_W) begin : g_bad_nproc
      $error("N_PROC must lie in 1..32");
   end
   if ((1 << SEL_W) < N_PROC + 1) begin : g_bad_selw
      $error("SEL_W too narrow for N_PROC windows");
   end

   logic              sys_hit, wr_mode;
   logic [N_PROC-1:0] mode, go_user, go_ctr;
   logic [WORD_W-1:0] unit_rdata [N_PROC];

   assign sys_hit = (bus_sel == '0);
   assign wr_mode = bus_wr && sys_hit && (bus_off == OFF_MODE);

   cpu_tmr_mode_reg #(.N_PROC(N_PROC)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mode (wr_mode),
      .wdata   (bus_wdata[N_PROC-1:0]),
      .mode    (mode),
      .go_user (go_user),
      .go_ctr  (go_ctr)
   );

   for (genvar i = 0; i < N_PROC; i++) begin : g_unit
      logic hit;
      assign hit = (bus_sel == SEL_W'(i + 1));
      cpu_tmr_unit u_unit (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .wr      (bus_wr && hit),
         .rd      (bus_rd && hit),
         .off     (bus_off),
         .wdata   (bus_wdata),
         .user    (mode[i]),
         .go_user (go_user[i]),
         .go_ctr  (go_ctr[i]),
         .rdata   (unit_rdata[i]),
         .irq     (proc_irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (sys_hit) begin
         if (bus_off == OFF_MODE) bus_rdata = WORD_W'(mode);
      end else begin
         for (int i = 0; i < N_PROC; i++)
            if (bus_sel == SEL_W'(i + 1)) bus_rdata = unit_rdata[i];
      end
   end

   a_r2_mode_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_hit && bus_off == OFF_MODE) |-> ((bus_rdata >> N_PROC) == '0));
   a_r7_sys_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_hit && bus_off == OFF_STAT) |-> (bus_rdata == '0));
   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_irq & mode) == '0);
endmodule

// File: tb/cpu_timer_bank_bench.sv
module cpu_timer_bank_bench;
   localparam int NP = 4;
   localparam int SW = 3;

   logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [SW-1:0] bus_sel = '0;
   logic [2:0]    bus_off = '0;
   logic [31:0]   bus_wdata = '0;
   wire  [31:0]   bus_rdata;
   wire  [NP-1:0] proc_irq;

   cpu_timer_bank #(.N_PROC(NP), .SEL_W(SW)) u_cpu_timer_bank (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_off(bus_off), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .proc_irq(proc_irq)
   );

   always #4 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [53:0]   m_cnt [NP];
   logic [21:0]   m_lim [NP];
   bit            m_rch [NP], m_run [NP], m_irq [NP];
   logic [NP-1:0] m_mode;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(int s, int o);
      int t;
      if (s == 0) return (o == 4) ? 32'(m_mode) : 32'h0;
      t = s - 1;
      if (m_mode[t]) begin
         case (o)
            0: return {m_rch[t], m_cnt[t][53:23]};
            1: return {m_cnt[t][22:0], 9'b0};
            3: return {31'b0, m_run[t]};
            default: return 32'h0;
         endcase
      end
      case (o)
         0: return {1'b0, m_lim[t], 9'b0};
         1: return {m_rch[t], m_cnt[t][21:0], 9'b0};
         3: return {31'b0, m_run[t]};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rd_tag(int s, int o);
      if (s == 0) return (o == 4) ? "R2" : "R7";
      if (o == 3) return "R7";
      return m_mode[s-1] ? "R5" : "R11";
   endfunction

   task automatic model_write(int s, int o, logic [31:0] d);
      int t;
      if (s == 0) begin
         if (o == 4) begin
            for (int i = 0; i < NP; i++) begin
               if (d[i] && !m_mode[i]) begin
                  m_irq[i] = 0; m_run[i] = 0;
               end else if (!d[i] && m_mode[i]) begin
                  m_cnt[i] = '0; m_lim[i] = '0; m_rch[i] = 0; m_run[i] = 1;
               end
            end
            m_mode = d[NP-1:0];
         end
         return;
      end
      t = s - 1;
      if (m_mode[t]) begin
         if (o == 0) begin m_cnt[t][53:23] = d[30:0]; m_rch[t] = 0; end
         else if (o == 1) begin m_cnt[t][22:0] = d[31:9]; m_rch[t] = 0; end
         else if (o == 3) m_run[t] = d[0];
      end else if (o == 0) begin
         m_lim[t] = d[30:9]; m_cnt[t] = '0; m_irq[t] = 0;
      end
   endtask

   task automatic bus_write(int s, int o, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = SW'(s); bus_off = 3'(o); bus_wdata = d;
      @(posedge clk);
      model_write(s, o, d);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(int s, int o, string tag, bit use_lit = 0, logic [31:0] lit = 0);
      @(negedge clk);
      bus_rd = 1'b1; bus_sel = SW'(s); bus_off = 3'(o);
      #1 check(tag, bus_rdata, use_lit ? lit : exp_rd(s, o));
      @(posedge clk);
      if (s != 0 && o == 0 && !m_mode[s-1]) begin
         m_rch[s-1] = 0; m_irq[s-1] = 0;
      end
      #1 bus_rd = 1'b0;
   endtask

   task automatic do_ticks(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         tick = 1'b1;
         @(posedge clk);
         for (int i = 0; i < NP; i++) begin
            if (!m_run[i]) continue;
            if (m_mode[i]) m_cnt[i] = m_cnt[i] + 1'b1;
            else if (m_lim[i] != 0 && (m_cnt[i][21:0] + 22'd1) == m_lim[i]) begin
               m_cnt[i] = '0; m_rch[i] = 1; m_irq[i] = 1;
            end else m_cnt[i] = 54'(m_cnt[i][21:0] + 22'd1);
         end
         #1 tick = 1'b0;
      end
   endtask

   task automatic check_irq();
      @(negedge clk);
      for (int i = 0; i < NP; i++)
         check(m_mode[i] ? "R9" : "R10", 32'(proc_irq[i]), 32'(m_irq[i]));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_mode = '0;
      for (int i = 0; i < NP; i++) begin
         m_cnt[i] = '0; m_lim[i] = '0; m_rch[i] = 0; m_run[i] = 1; m_irq[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      check("R1", 32'(proc_irq), 32'h0);
      bus_read(0, 4, "R1", 1, 32'h0);
      for (int s = 1; s <= NP; s++) begin
         bus_read(s, 1, "R1", 1, 32'h0);
         bus_read(s, 3, "R1", 1, 32'h1);
      end
      // R2 mode register and dropped upper bits
      bus_write(0, 4, 32'h35);
      bus_read(0, 4, "R2", 1, 32'h5);
      bus_write(1, 4, 32'hF);
      bus_read(0, 4, "R2", 1, 32'h5);
      // R3 user entry stops timer
      bus_read(1, 3, "R3", 1, 32'h0);
      // R6 loads
      bus_write(1, 1, 32'hFFFF_FE00);
      bus_write(1, 0, 32'h0000_0005);
      bus_read(1, 1, "R6", 1, 32'hFFFF_FE00);
      bus_read(1, 0, "R6", 1, 32'h0000_0005);
      // R7 start, R8 carry
      bus_write(1, 3, 32'h1);
      bus_read(1, 3, "R7", 1, 32'h1);
      do_ticks(1);
      bus_read(1, 1, "R8", 1, 32'h0);
      bus_read(1, 0, "R8", 1, 32'h6);
      bus_write(1, 3, 32'h0);
      do_ticks(3);
      bus_read(1, 1, "R8", 1, 32'h0);
      // R10 / R11 counter mode on timer 2
      bus_write(2, 0, 32'h600);
      do_ticks(3);
      @(negedge clk);
      check("R10", 32'(proc_irq[1]), 32'h1);
      bus_read(2, 1, "R11", 1, 32'h8000_0000);
      bus_read(2, 0, "R11", 1, 32'h600);
      @(negedge clk);
      check("R11", 32'(proc_irq[1]), 32'h0);
      bus_write(2, 1, 32'h1234_5600);
      bus_read(2, 1, "R11", 1, 32'h0);
      bus_write(2, 3, 32'h0);
      bus_read(2, 3, "R7", 1, 32'h1);
      bus_read(0, 3, "R7", 1, 32'h0);
      // R4 leave user mode on timer 1
      bus_write(0, 4, 32'h4);
      bus_read(1, 1, "R4", 1, 32'h0);
      bus_read(1, 3, "R4", 1, 32'h1);
      bus_read(1, 0, "R4", 1, 32'h0);
      // R9 running user timer 3 never interrupts
      bus_write(3, 3, 32'h1);
      do_ticks(6);
      check_irq();
      // random phase
      void'($urandom(32'd1234));
      for (int it = 0; it < 400; it++) begin
         int op, s, o;
         logic [31:0] d;
         op = $urandom % 10;
         s  = $urandom % (NP + 1);
         o  = $urandom % 5;
         if (op < 3) begin
            do_ticks(1 + $urandom % 6);
            check_irq();
         end else if (op < 4) begin
            bus_write(0, 4, 32'($urandom % 64));
         end else if (op < 7) begin
            d = $urandom;
            if (s != 0 && o == 0 && !m_mode[s-1]) d = 32'(($urandom % 6) << 9);
            if (s == 0 && o == 4) d = 32'($urandom % 64);
            bus_write(s, o, d);
         end else begin
            bus_read(s, o, rd_tag(s, o));
         end
      end
      check_irq();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule